// File: doc/BRIEF.md
# Burst Bus Target with Wait-State Insertion

This block is the target side of a synchronous, multiplexed address/data bus that uses active-low framing and ready signals. The initiator opens a transaction by pulling the transaction line low. In that first cycle it puts a command and a word address on the shared lines. If the address falls inside the block's window and the command is a read or a write, the block claims the transaction with its select line. It then moves one word in every clock edge where both its own ready line and the initiator's ready line are low.

A burst has no preset length. The word index steps by one after every completed transfer and wraps inside the window. The initiator lets the transaction line go high while it still wants exactly one more word, and the block releases the bus after that word. Data lives in a small register file. Writes take the word from the shared lines. Reads drive it onto them, but only after one idle turnaround cycle in which neither side drives. A parameter sets how many cycles the ready line stays high before each data phase.

Top module: `pci_burst_target`

## Requirements
- R1: After reset the select and ready outputs are high, the drive enable is low and every stored word reads as zero.
- R2: A transaction whose first-cycle address lies in BASE..BASE+NWORDS-1 (word addresses, BASE aligned to NWORDS) with command 4'b0110 (read) or 4'b0111 (write) pulls the select output low in the next cycle. Select stays low until the transaction ends.
- R3: A transaction with any other command, or with an address outside the window, never pulls select or ready low, never enables the drivers and leaves stored words unchanged. The block returns to idle once the transaction and initiator-ready lines are both high.
- R4: A word moves only at an edge where both ready lines are low. While the initiator holds its ready line high, nothing is written and the word index does not advance.
- R5: The first word uses the index in the low log2(NWORDS) address bits. Each completed transfer adds one, modulo NWORDS.
- R6: On a write, the shared-line value at a completing edge is stored at the current index.
- R7: On a read, the block drives the stored word at the current index onto its output lines, with the drive enable high, while its ready line is low.
- R8: On a read, the drive enable stays low in the cycle after the address cycle (turnaround). Ready stays high for 1+WAIT_CYC cycles before the first data phase.
- R9: Ready stays high for WAIT_CYC cycles before the first write data phase and before every later data phase of either direction.
- R10: A transfer that completes while the transaction line is high ends the transaction. In the next cycle select and ready are high and the drive enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_n | input | 1 | Transaction line from the initiator, low while more than one word remains |
| mst_rdy_n | input | 1 | Initiator ready, active low |
| bus_cmd | input | 4 | Command, valid in the address cycle |
| bus_ad_i | input | BUS_W | Shared lines as seen by the target: address, then write data |
| bus_ad_o | output | BUS_W | Read data driven by the target |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| slv_sel_n | output | 1 | Target claims the transaction, active low |
| slv_rdy_n | output | 1 | Target ready, active low |

## Verification
Every output is registered, so each result follows its cause by a fixed count of edges. Select and the turnaround level appear one edge after the address cycle. Ready falls WAIT_CYC edges after a write address cycle or a completed transfer, and 1+WAIT_CYC edges after a read address cycle. The release appears one edge after the final transfer. The bench drives and samples on the falling edge, so each level it reads was set by the preceding rising edge. It counts the falling edges on which ready is high and compares that count with the expected wait number. It checks read data on the falling edge just before the edge that completes the transfer, and it checks the release on the falling edge right after the last transfer.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_XFER = 2'd2,
        ST_SKIP = 2'd3
    } pcit_state_t;

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode #(
    parameter int              BUS_W  = 32,
    parameter int              IDX_W  = 4,
    parameter logic [BUS_W-1:0] BASE  = '0,
    parameter logic [3:0]      CMD_RD = 4'b0110,
    parameter logic [3:0]      CMD_WR = 4'b0111
) (
    input  logic [BUS_W-1:0] addr,
    input  logic [3:0]       cmd,
    output logic             hit,
    output logic             cmd_rd,
    output logic             cmd_wr,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit    = (addr[BUS_W-1:IDX_W] == BASE[BUS_W-1:IDX_W]);
        cmd_rd = (cmd == CMD_RD);
        cmd_wr = (cmd == CMD_WR);
        idx    = addr[IDX_W-1:0];
    end

endmodule

// File: rtl/pcit_regfile.sv
module pcit_regfile #(
    parameter int NWORDS = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_d;
        logic [DATA_W-1:0] word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words[g] = word_q;
    end

    assign rd_data = words[rd_idx];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (words[$past(wr_idx)] == $past(wr_data))) // R6
        else $error("write did not land");

endmodule

// File: rtl/pcit_ctrl.sv
module pcit_ctrl
    import pcit_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int WAIT_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_n,
    input  logic             mst_rdy_n,
    input  logic             hit,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [IDX_W-1:0] start_idx,
    output logic             sel_n,
    output logic             rdy_n,
    output logic             oe,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en
);

    localparam int               CNT_W   = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC);
    localparam logic             NO_WAIT = (WAIT_CYC == 0);

    typedef struct packed {
        pcit_state_t      st;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] wcnt;
        logic             sel_n;
        logic             rdy_n;
        logic             oe;
    } ctrl_regs_t;

    ctrl_regs_t r_d;
    ctrl_regs_t r_q;

    always_comb begin
        r_d   = r_q;
        wr_en = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (!txn_n) begin
                    if (hit && (cmd_rd || cmd_wr)) begin
                        r_d.sel_n = 1'b0;
                        r_d.rd    = cmd_rd;
                        r_d.idx   = start_idx;
                        r_d.wcnt  = WAIT_LD;
                        if (cmd_rd) begin
                            r_d.st = ST_TURN;
                        end else begin
                            r_d.st    = ST_XFER;
                            r_d.rdy_n = !NO_WAIT;
                        end
                    end else begin
                        r_d.st = ST_SKIP;
                    end
                end
            end
            ST_TURN: begin
                r_d.oe    = 1'b1;
                r_d.st    = ST_XFER;
                r_d.wcnt  = WAIT_LD;
                r_d.rdy_n = !NO_WAIT;
            end
            ST_XFER: begin
                if (txn_n && mst_rdy_n) begin
                    r_d.st    = ST_IDLE;
                    r_d.sel_n = 1'b1;
                    r_d.rdy_n = 1'b1;
                    r_d.oe    = 1'b0;
                end else if (r_q.rdy_n) begin
                    r_d.wcnt = r_q.wcnt - 1'b1;
                    if (r_q.wcnt == CNT_W'(1)) begin
                        r_d.rdy_n = 1'b0;
                    end
                end else if (!mst_rdy_n) begin
                    wr_en   = !r_q.rd;
                    r_d.idx = r_q.idx + 1'b1;
                    if (txn_n) begin
                        r_d.st    = ST_IDLE;
                        r_d.sel_n = 1'b1;
                        r_d.rdy_n = 1'b1;
                        r_d.oe    = 1'b0;
                    end else begin
                        r_d.wcnt  = WAIT_LD;
                        r_d.rdy_n = !NO_WAIT;
                    end
                end
            end
            ST_SKIP: begin
                if (txn_n && mst_rdy_n) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rd: 1'b0, idx: '0, wcnt: '0,
                     sel_n: 1'b1, rdy_n: 1'b1, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_n = r_q.sel_n;
    assign rdy_n = r_q.rdy_n;
    assign oe    = r_q.oe;
    assign idx   = r_q.idx;

    AST_RDY_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> !sel_n) // R2
        else $error("ready without select");

    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !sel_n) // R7
        else $error("drive without select");

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SKIP) |-> (sel_n && rdy_n && !oe)) // R3
        else $error("ignored transaction driven");

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !txn_n && hit && cmd_rd) |=> (!sel_n && !oe && rdy_n)) // R8
        else $error("no turnaround before read drive");

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && mst_rdy_n && !txn_n) |=> ($stable(idx) && !rdy_n)) // R4
        else $error("index moved during initiator stall");

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !mst_rdy_n) |=> (idx == IDX_W'($past(idx) + 1'b1))) // R5
        else $error("index did not step");

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !mst_rdy_n && txn_n) |=> (sel_n && rdy_n && !oe)) // R10
        else $error("bus not released after last word");

endmodule

// File: rtl/pci_burst_target.sv
module pci_burst_target #(
    parameter int              BUS_W    = 32,
    parameter int              NWORDS   = 16,
    parameter logic [BUS_W-1:0] BASE    = 32'h0000_0100,
    parameter int              WAIT_CYC = 1,
    parameter logic [3:0]      CMD_RD   = 4'b0110,
    parameter logic [3:0]      CMD_WR   = 4'b0111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_n,
    input  logic             mst_rdy_n,
    input  logic [3:0]       bus_cmd,
    input  logic [BUS_W-1:0] bus_ad_i,
    output logic [BUS_W-1:0] bus_ad_o,
    output logic             bus_ad_oe,
    output logic             slv_sel_n,
    output logic             slv_rdy_n
);

    localparam int IDX_W = $clog2(NWORDS);

    logic             hit;
    logic             cmd_rd;
    logic             cmd_wr;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] cur_idx;
    logic             wr_en;
    logic [BUS_W-1:0] rd_data;

    pcit_decode #(
        .BUS_W  (BUS_W),
        .IDX_W  (IDX_W),
        .BASE   (BASE),
        .CMD_RD (CMD_RD),
        .CMD_WR (CMD_WR)
    ) u_decode (
        .addr   (bus_ad_i),
        .cmd    (bus_cmd),
        .hit    (hit),
        .cmd_rd (cmd_rd),
        .cmd_wr (cmd_wr),
        .idx    (start_idx)
    );

    pcit_ctrl #(
        .IDX_W    (IDX_W),
        .WAIT_CYC (WAIT_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_n     (txn_n),
        .mst_rdy_n (mst_rdy_n),
        .hit       (hit),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .start_idx (start_idx),
        .sel_n     (slv_sel_n),
        .rdy_n     (slv_rdy_n),
        .oe        (bus_ad_oe),
        .idx       (cur_idx),
        .wr_en     (wr_en)
    );

    pcit_regfile #(
        .NWORDS (NWORDS),
        .DATA_W (BUS_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_data (bus_ad_i),
        .rd_idx  (cur_idx),
        .rd_data (rd_data)
    );

    assign bus_ad_o = bus_ad_oe ? rd_data : '0;

endmodule

// File: tb/pci_burst_target_tb.sv
`timescale 1ns/1ps
module pci_burst_target_tb;

    localparam int          NW    = 16;
    localparam logic [31:0] BASE  = 32'h0000_0100;
    localparam int          WAITC = 1;
    localparam logic [3:0]  RD    = 4'b0110;
    localparam logic [3:0]  WR    = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_n = 1'b1;
    logic        mst_rdy_n = 1'b1;
    logic [3:0]  bus_cmd = 4'h0;
    logic [31:0] bus_ad_i = '0;
    logic [31:0] bus_ad_o;
    logic        bus_ad_oe;
    logic        slv_sel_n;
    logic        slv_rdy_n;

    logic [31:0] mem_m [NW];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pci_burst_target #(
        .BUS_W(32), .NWORDS(NW), .BASE(BASE), .WAIT_CYC(WAITC),
        .CMD_RD(RD), .CMD_WR(WR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .txn_n(txn_n), .mst_rdy_n(mst_rdy_n),
        .bus_cmd(bus_cmd), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
        .bus_ad_oe(bus_ad_oe), .slv_sel_n(slv_sel_n), .slv_rdy_n(slv_rdy_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One burst as initiator; stall_at inserts two initiator wait cycles before that word.
    task automatic burst(input bit rd, input logic [31:0] addr, input int n,
                         input logic [31:0] seed, input int stall_at);
        int unsigned a0;
        a0 = addr;
        @(negedge clk);
        txn_n = 1'b0; mst_rdy_n = 1'b1; bus_cmd = rd ? RD : WR; bus_ad_i = addr;
        @(negedge clk);
        chk(slv_sel_n == 1'b0, "R2 select after address", {31'd0, slv_sel_n}, 32'd0);
        if (rd) chk(bus_ad_oe == 1'b0, "R8 turnaround", {31'd0, bus_ad_oe}, 32'd0);
        for (int k = 0; k < n; k++) begin
            int waits;
            int exp_w;
            int ix;
            ix = int'((a0 + k) % NW);
            waits = 0;
            txn_n = (k == n - 1);
            if (k == stall_at) begin
                mst_rdy_n = 1'b1;
                bus_ad_i = 32'hDEAD_BEEF;
                repeat (2) begin
                    if (slv_rdy_n) waits++;
                    @(negedge clk);
                end
                chk(slv_sel_n == 1'b0, "R4 held through stall", {31'd0, slv_sel_n}, 32'd0);
            end
            mst_rdy_n = 1'b0;
            bus_ad_i = rd ? 32'd0 : seed + k;
            while (slv_rdy_n && waits < 30) begin
                waits++;
                @(negedge clk);
            end
            exp_w = (k == 0 && rd) ? 1 + WAITC : WAITC;
            chk(waits == exp_w, (k == 0 && rd) ? "R8 first read wait" : "R9 wait states",
                waits, exp_w);
            if (rd) begin
                chk(bus_ad_oe && bus_ad_o == mem_m[ix], "R7 R5 read data", bus_ad_o, mem_m[ix]);
            end else begin
                mem_m[ix] = seed + k;
            end
            @(negedge clk);
        end
        mst_rdy_n = 1'b1;
        chk(slv_sel_n && slv_rdy_n && !bus_ad_oe, "R10 release",
            {29'd0, slv_sel_n, slv_rdy_n, bus_ad_oe}, 32'd6);
        @(negedge clk);
    endtask

    // Transaction the target must not claim.
    task automatic ignored(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] dat);
        @(negedge clk);
        txn_n = 1'b0; mst_rdy_n = 1'b1; bus_cmd = cmd; bus_ad_i = addr;
        @(negedge clk);
        txn_n = 1'b1; mst_rdy_n = 1'b0; bus_ad_i = dat;
        repeat (4) begin
            chk(slv_sel_n && slv_rdy_n && !bus_ad_oe, "R3 not claimed",
                {29'd0, slv_sel_n, slv_rdy_n, bus_ad_oe}, 32'd6);
            @(negedge clk);
        end
        mst_rdy_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        chk(slv_sel_n && slv_rdy_n && !bus_ad_oe, "R1 reset outputs",
            {29'd0, slv_sel_n, slv_rdy_n, bus_ad_oe}, 32'd6);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: stored words start at zero
        burst(1'b1, BASE, 4, 32'd0, -1);
        // R6 burst write, R7 read back across it
        burst(1'b0, BASE + 2, 5, 32'hA000_0000, -1);
        burst(1'b1, BASE + 1, 6, 32'd0, -1);
        // R5 wrap at the top of the window
        burst(1'b0, BASE + 14, 4, 32'hB000_0010, -1);
        burst(1'b1, BASE + 14, 4, 32'd0, -1);
        // R4 initiator stalls mid burst
        burst(1'b0, BASE + 8, 3, 32'hC000_0000, 1);
        burst(1'b1, BASE + 7, 4, 32'd0, 2);
        // single-word transactions
        burst(1'b0, BASE + 3, 1, 32'hD000_0003, -1);
        burst(1'b1, BASE + 3, 1, 32'd0, -1);
        // R3 unknown command and out-of-window address leave data intact
        ignored(4'b0011, BASE + 2, 32'h5555_5555);
        ignored(WR, BASE + NW + 2, 32'h6666_6666);
        ignored(RD, BASE - NW, 32'h0);
        burst(1'b1, BASE + 2, 2, 32'd0, -1);
        done = 1'b1;
        report();
    end

endmodule